// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small byte-addressed data cache placed between a processor request port and a slower memory that moves whole blocks. It is two-way set associative. Each line carries a valid bit, a dirty bit, a tag and one block of data, and each set carries one bit that names its least recently used way. Both ways of the indexed set are compared in parallel. On a hit the byte picked by the offset bits is returned, or the write byte is merged into the line and the line is marked dirty.

On a miss a victim is chosen: an invalid way first, way 0 when both are invalid, otherwise the least recently used way. A dirty victim is written back as a whole block before the missing block is read in. A mode input selects how write misses are handled. In allocate mode the block is fetched and the byte is merged into it. In no-allocate mode the byte goes straight to memory as a single-byte write and the cache is left untouched. Only one request is in flight at a time.

Top module: `wb_cache2w`

## Requirements
- R1: An address splits into offset = bit 0, set index = bit 1 and tag = bits 7:2. Addresses that share an index but differ in tag compete for the same set.
- R2: A request hits when either way of the indexed set is valid and holds the request tag. A read hit returns byte `offset` of the block, where block byte k sits at bits 8k+7:8k. A hit completes with `cpu_done` high on the second rising edge after acceptance and makes no memory transfer.
- R3: A synchronous reset clears every valid, dirty and LRU bit. After reset `cpu_ready` is high, `cpu_done` and `mem_req` are low, and every access misses.
- R4: A miss fills an invalid way when the set has one, taking way 0 when both ways are invalid.
- R5: Every hit and every fill makes the accessed way most recently used. A miss in a full set replaces the least recently used way.
- R6: A write hit updates the byte in the cache and marks the line dirty, with no memory transfer. Later reads return the new byte.
- R7: Before a dirty victim is replaced, its block is written to its own block address with `mem_blk_wr`, and only then is the new block read. A clean victim is never written back.
- R8: With `mode_alloc`=1, a write miss fetches the block, merges the byte into it and leaves the line valid and dirty.
- R9: With `mode_alloc`=0, a write miss issues one `mem_byte_wr` transfer at the full address and changes no tag, valid, dirty or LRU state. A write hit still behaves as in R6.
- R10: `cpu_ready` is high only when the cache is idle. It falls on the cycle after a request is accepted and rises with the one-cycle `cpu_done` pulse. `mem_req` is low while the cache is ready.
- R11: From reset, the reads 0x00, 0x01, 0x63, 0x61, 0x62, 0x00, 0x64 give miss, hit, miss, miss, hit, hit, miss.
- R12: A memory request keeps its address and kind stable until `mem_ack`. At most one of `mem_blk_wr` and `mem_byte_wr` is set, and a request with neither set is a block read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_alloc | input | 1 | 1 = allocate on write miss, 0 = forward write miss to memory |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Cache idle and able to accept a request |
| cpu_addr | input | 8 | Byte address |
| cpu_we | input | 1 | 1 = byte write, 0 = read |
| cpu_wdata | input | 8 | Write byte |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed request hit, valid with cpu_done |
| cpu_rdata | output | 8 | Read byte, valid with cpu_done |
| mem_req | output | 1 | Memory transfer request, held until mem_ack |
| mem_blk_wr | output | 1 | Request is a block writeback |
| mem_byte_wr | output | 1 | Request is a single-byte write |
| mem_addr | output | 8 | Block address, or byte address for a byte write |
| mem_wblk | output | 16 | Block written back |
| mem_wbyte | output | 8 | Byte for a single-byte write |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |
| mem_rblk | input | 16 | Block read data, valid with mem_ack |

## Verification
The properties assume that `mem_ack` arrives only while `mem_req` is high, lasts one cycle, and is followed by at least one low cycle. They also assume that the processor presents a request only when `cpu_ready` is high. The bench memory acknowledges after a fixed delay, then drops the acknowledge for a cycle, and it never answers an idle port. The bench drives `cpu_valid` for a single cycle, only while the cache is idle, and it changes `mode_alloc` only between transactions.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_EVICT,
      ST_REFILL,
      ST_BYPASS
   } cstate_t;
endpackage

// File: rtl/wbc_way_match.sv
module wbc_way_match #(
   parameter int TAG_W = 6
) (
   input  logic             valid_i,
   input  logic [TAG_W-1:0] stored_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             match_o
);
   assign match_o = valid_i && (stored_i == tag_i);
endmodule

// File: rtl/wbc_victim.sv
module wbc_victim #(
   parameter int WAYS = 2,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  valid_i,
   input  logic [WAY_W-1:0] lru_i,
   output logic [WAY_W-1:0] way_o
);
   always_comb begin
      way_o = lru_i;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_i[w]) way_o = WAY_W'(w);
      end
   end
endmodule

// File: rtl/wbc_byte_lane.sv
module wbc_byte_lane #(
   parameter int BYTES = 2,
   parameter int DW    = 8,
   localparam int OFF_W = $clog2(BYTES),
   localparam int BLK_W = BYTES * DW
) (
   input  logic [BLK_W-1:0] blk_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [DW-1:0]    byte_i,
   output logic [DW-1:0]    rd_o,
   output logic [BLK_W-1:0] merged_o
);
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign merged_o[b*DW +: DW] = (off_i == OFF_W'(b)) ? byte_i : blk_i[b*DW +: DW];
   end

   always_comb begin
      rd_o = '0;
      for (int b = 0; b < BYTES; b++) begin
         if (off_i == OFF_W'(b)) rd_o = blk_i[b*DW +: DW];
      end
   end
endmodule

// File: rtl/wb_cache2w.sv
module wb_cache2w #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SETS        = 2,
   parameter int WAYS        = 2,
   parameter int BLOCK_BYTES = 2,
   localparam int OFF_W = $clog2(BLOCK_BYTES),
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
   localparam int WAY_W = $clog2(WAYS),
   localparam int BLK_W = BLOCK_BYTES * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_alloc,
   input  logic              cpu_valid,
   output logic              cpu_ready,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_blk_wr,
   output logic              mem_byte_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BLK_W-1:0]  mem_wblk,
   output logic [DATA_W-1:0] mem_wbyte,
   input  logic              mem_ack,
   input  logic [BLK_W-1:0]  mem_rblk
);
   import wbc_pkg::*;

   if (WAYS != 2) begin : g_bad_ways
      $error("wb_cache2w: one LRU bit per set needs WAYS == 2");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("wb_cache2w: SETS must be a power of two, at least 2");
   end
   if (BLOCK_BYTES < 2 || (1 << OFF_W) != BLOCK_BYTES) begin : g_bad_blk
      $error("wb_cache2w: BLOCK_BYTES must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wb_cache2w: address too narrow for the geometry");
   end

   cstate_t state_q;

   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [BLK_W-1:0] data_q  [SETS][WAYS];
   logic             valid_q [SETS][WAYS];
   logic             dirty_q [SETS][WAYS];
   logic [WAY_W-1:0] lru_q   [SETS];

   logic [ADDR_W-1:0] req_addr_q;
   logic              req_we_q;
   logic [DATA_W-1:0] req_wdata_q;

   logic              done_q, hit_q;
   logic [DATA_W-1:0] rdata_q;

   logic [TAG_W-1:0] r_tag;
   logic [IDX_W-1:0] r_idx;
   logic [OFF_W-1:0] r_off;

   assign r_tag = req_addr_q[ADDR_W-1 -: TAG_W];
   assign r_idx = req_addr_q[OFF_W +: IDX_W];
   assign r_off = req_addr_q[OFF_W-1:0];

   logic [WAYS-1:0] match, set_valid;
   logic [WAY_W-1:0] hit_way, vict_way;
   logic hit_any;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign set_valid[w] = valid_q[r_idx][w];
      wbc_way_match #(.TAG_W(TAG_W)) u_match (
         .valid_i (valid_q[r_idx][w]),
         .stored_i(tag_q[r_idx][w]),
         .tag_i   (r_tag),
         .match_o (match[w])
      );
   end

   assign hit_any = |match;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end

   wbc_victim #(.WAYS(WAYS)) u_victim (
      .valid_i(set_valid),
      .lru_i  (lru_q[r_idx]),
      .way_o  (vict_way)
   );

   logic [DATA_W-1:0] hit_rd, fill_rd;
   logic [BLK_W-1:0]  hit_merged, fill_merged;

   wbc_byte_lane #(.BYTES(BLOCK_BYTES), .DW(DATA_W)) u_hit_lane (
      .blk_i   (data_q[r_idx][hit_way]),
      .off_i   (r_off),
      .byte_i  (req_wdata_q),
      .rd_o    (hit_rd),
      .merged_o(hit_merged)
   );

   wbc_byte_lane #(.BYTES(BLOCK_BYTES), .DW(DATA_W)) u_fill_lane (
      .blk_i   (mem_rblk),
      .off_i   (r_off),
      .byte_i  (req_wdata_q),
      .rd_o    (fill_rd),
      .merged_o(fill_merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         hit_q   <= 1'b0;
         rdata_q <= '0;
         for (int s = 0; s < SETS; s++) begin
            lru_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               valid_q[s][w] <= 1'b0;
               dirty_q[s][w] <= 1'b0;
            end
         end
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_valid) begin
                  req_addr_q  <= cpu_addr;
                  req_we_q    <= cpu_we;
                  req_wdata_q <= cpu_wdata;
                  state_q     <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (hit_any) begin
                  done_q        <= 1'b1;
                  hit_q         <= 1'b1;
                  rdata_q       <= req_we_q ? req_wdata_q : hit_rd;
                  lru_q[r_idx]  <= ~hit_way;
                  if (req_we_q) begin
                     data_q[r_idx][hit_way]  <= hit_merged;
                     dirty_q[r_idx][hit_way] <= 1'b1;
                  end
                  state_q <= ST_IDLE;
               end else if (req_we_q && !mode_alloc) begin
                  state_q <= ST_BYPASS;
               end else if (valid_q[r_idx][vict_way] && dirty_q[r_idx][vict_way]) begin
                  state_q <= ST_EVICT;
               end else begin
                  state_q <= ST_REFILL;
               end
            end
            ST_EVICT: begin
               if (mem_ack) begin
                  dirty_q[r_idx][vict_way] <= 1'b0;
                  state_q                  <= ST_REFILL;
               end
            end
            ST_REFILL: begin
               if (mem_ack) begin
                  data_q[r_idx][vict_way]  <= req_we_q ? fill_merged : mem_rblk;
                  tag_q[r_idx][vict_way]   <= r_tag;
                  valid_q[r_idx][vict_way] <= 1'b1;
                  dirty_q[r_idx][vict_way] <= req_we_q;
                  lru_q[r_idx]             <= ~vict_way;
                  done_q                   <= 1'b1;
                  hit_q                    <= 1'b0;
                  rdata_q                  <= req_we_q ? req_wdata_q : fill_rd;
                  state_q                  <= ST_IDLE;
               end
            end
            ST_BYPASS: begin
               if (mem_ack) begin
                  done_q  <= 1'b1;
                  hit_q   <= 1'b0;
                  rdata_q <= req_wdata_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready   = (state_q == ST_IDLE);
   assign cpu_done    = done_q;
   assign cpu_hit     = hit_q;
   assign cpu_rdata   = rdata_q;
   assign mem_req     = (state_q == ST_EVICT) || (state_q == ST_REFILL) || (state_q == ST_BYPASS);
   assign mem_blk_wr  = (state_q == ST_EVICT);
   assign mem_byte_wr = (state_q == ST_BYPASS);
   assign mem_wblk    = data_q[r_idx][vict_way];
   assign mem_wbyte   = req_wdata_q;

   always_comb begin
      unique case (state_q)
         ST_EVICT:  mem_addr = {tag_q[r_idx][vict_way], r_idx, {OFF_W{1'b0}}};
         ST_BYPASS: mem_addr = req_addr_q;
         default:   mem_addr = {r_tag, r_idx, {OFF_W{1'b0}}};
      endcase
   end
endmodule

// File: rtl/wb_cache2w_chk.sv
module wb_cache2w_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_valid,
   input logic              cpu_ready,
   input logic              cpu_done,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_blk_wr,
   input logic              mem_byte_wr,
   input logic [ADDR_W-1:0] mem_addr
);
   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> cpu_ready && !mem_req && !cpu_done);                          // R3

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
      cpu_valid && cpu_ready |=> !cpu_ready);                                      // R10

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      cpu_done |-> cpu_ready);                                                     // R10

   AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |-> !mem_req);                                                     // R10

   AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !(mem_blk_wr && mem_byte_wr));                                   // R12

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_blk_wr) && $stable(mem_byte_wr)); // R12

   AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
      mem_req && mem_blk_wr && mem_ack |=> mem_req && !mem_blk_wr && !mem_byte_wr); // R7
endmodule

bind wb_cache2w wb_cache2w_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/wb_cache2w_test.sv
`timescale 1ns/1ps
module wb_cache2w_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode_alloc = 1'b1;
   logic        cpu_valid = 1'b0;
   logic        cpu_ready;
   logic [7:0]  cpu_addr = '0;
   logic        cpu_we = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_done, cpu_hit;
   logic [7:0]  cpu_rdata;
   logic        mem_req, mem_blk_wr, mem_byte_wr;
   logic [7:0]  mem_addr, mem_wbyte;
   logic [15:0] mem_wblk;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rblk = '0;

   wb_cache2w uut (
      .clk(clk), .rst(rst), .mode_alloc(mode_alloc),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
      .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
      .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_blk_wr(mem_blk_wr), .mem_byte_wr(mem_byte_wr),
      .mem_addr(mem_addr), .mem_wblk(mem_wblk), .mem_wbyte(mem_wbyte),
      .mem_ack(mem_ack), .mem_rblk(mem_rblk)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int xfers  = 0;

   // backing memory driven by the cache's transfers
   logic [7:0] mem [256];
   int lat_cnt = 0;
   localparam int MEM_LAT = 2;

   always @(posedge clk) begin
      if (rst) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_req) begin
         if (lat_cnt == MEM_LAT) begin
            mem_ack <= 1'b1;
            xfers   <= xfers + 1;
            if (mem_blk_wr) begin
               mem[{mem_addr[7:1], 1'b0}] <= mem_wblk[7:0];
               mem[{mem_addr[7:1], 1'b1}] <= mem_wblk[15:8];
            end else if (mem_byte_wr) begin
               mem[mem_addr] <= mem_wbyte;
            end else begin
               mem_rblk <= {mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]};
            end
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   // reference model: line state per set/way, latest value of every byte, expected memory image
   bit       m_v [2][2];
   bit       m_d [2][2];
   int       m_t [2][2];
   int       m_lru [2];
   bit [7:0] shadow [256];
   bit [7:0] gmem [256];

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < 2; s++) begin
         m_lru[s] = 0;
         for (int w = 0; w < 2; w++) begin
            m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0;
         end
      end
      for (int i = 0; i < 256; i++) shadow[i] = gmem[i];
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      model_reset();
      @(negedge clk);
      chk("R3", "ready after reset", int'(cpu_ready), 1);
      chk("R3", "done after reset", int'(cpu_done), 0);
      chk("R3", "mem_req after reset", int'(mem_req), 0);
   endtask

   // one processor access; returns the observed hit flag
   task automatic access(input logic [7:0] a, input bit we, input logic [7:0] wd,
                         input bit alloc, input string req, output bit got_hit);
      int idx, tg, hw, vw, exp_x, x0, n;
      bit exp_hit;
      logic [7:0] exp_rd;
      idx = int'(a[1]);
      tg  = int'(a[7:2]);
      exp_hit = 0; hw = 0; exp_x = 0;
      for (int w = 0; w < 2; w++) if (m_v[idx][w] && m_t[idx][w] == tg) begin exp_hit = 1; hw = w; end
      exp_rd = shadow[a];
      if (exp_hit) begin
         m_lru[idx] = 1 - hw;
         if (we) begin m_d[idx][hw] = 1; shadow[a] = wd; end
      end else if (we && !alloc) begin
         exp_x = 1; gmem[a] = wd; shadow[a] = wd;
      end else begin
         if (!m_v[idx][0]) vw = 0; else if (!m_v[idx][1]) vw = 1; else vw = m_lru[idx];
         exp_x = 1;
         if (m_v[idx][vw] && m_d[idx][vw]) begin
            int ba;
            ba = (m_t[idx][vw] << 2) | (idx << 1);
            gmem[ba] = shadow[ba]; gmem[ba + 1] = shadow[ba + 1];
            exp_x = 2;
         end
         m_v[idx][vw] = 1; m_t[idx][vw] = tg; m_d[idx][vw] = we; m_lru[idx] = 1 - vw;
         if (we) shadow[a] = wd;
      end

      chk("R10", "ready before request", int'(cpu_ready), 1);
      mode_alloc = alloc; cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_valid = 1'b1;
      x0 = xfers;
      @(negedge clk);
      cpu_valid = 1'b0;
      n = 0;
      got_hit = 0;
      forever begin
         @(negedge clk);
         n++;
         if (cpu_done) break;
         chk("R10", "ready low while busy", int'(cpu_ready), 0);
         if (n > 100) begin
            chk("R10", "watchdog on completion", 0, 1);
            break;
         end
      end
      got_hit = cpu_hit;
      chk(req, $sformatf("hit flag @%02h", a), int'(cpu_hit), int'(exp_hit));
      if (!we) chk(req, $sformatf("read data @%02h", a), int'(cpu_rdata), int'(exp_rd));
      if (exp_hit) chk("R2", "hit latency", n, 1);
      chk("R7", $sformatf("memory transfers @%02h", a), xfers - x0, exp_x);
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < 256; i++) if (mem[i] !== gmem[i]) bad++;
         chk("R7", "backing memory image", bad, 0);
      end
   endtask

   // every clock: transfer kinds are exclusive
   always @(negedge clk) begin
      cycles++;
      if (!rst && mem_req && mem_blk_wr && mem_byte_wr)
         chk("R12", "both write strobes", 1, 0);
   end

   initial begin
      bit h;
      int seed;
      for (int i = 0; i < 256; i++) begin
         mem[i]  = 8'(i * 37 + 11);
         gmem[i] = 8'(i * 37 + 11);
      end
      do_reset();

      // R11 reference sequence, R1 split and R4 fill order
      begin
         logic [7:0] seq [7] = '{8'h00, 8'h01, 8'h63, 8'h61, 8'h62, 8'h00, 8'h64};
         bit exp [7] = '{0, 1, 0, 0, 1, 1, 0};
         for (int k = 0; k < 7; k++) begin
            access(seq[k], 0, 8'h00, 1, "R1", h);
            chk("R11", $sformatf("sequence step %0d", k), int'(h), int'(exp[k]));
         end
      end

      // R4 / R5 in set 1
      access(8'h0B, 0, 8'h00, 1, "R4", h);
      access(8'h63, 0, 8'h00, 1, "R5", h);
      access(8'h13, 0, 8'h00, 1, "R5", h);
      access(8'h63, 0, 8'h00, 1, "R5", h);
      chk("R5", "MRU line kept", int'(h), 1);
      access(8'h0B, 0, 8'h00, 1, "R5", h);
      chk("R5", "LRU line evicted", int'(h), 0);

      // R6 write hit, then R7 dirty eviction
      access(8'h01, 1, 8'hA5, 1, "R6", h);
      access(8'h01, 0, 8'h00, 1, "R6", h);
      access(8'h04, 0, 8'h00, 1, "R7", h);
      access(8'h08, 0, 8'h00, 1, "R7", h);
      access(8'h01, 0, 8'h00, 1, "R7", h);

      // R8 allocate on write miss
      access(8'h21, 1, 8'h3C, 1, "R8", h);
      access(8'h21, 0, 8'h00, 1, "R8", h);
      chk("R8", "allocated line hits", int'(h), 1);
      access(8'h20, 0, 8'h00, 1, "R8", h);

      // R9 no-allocate write miss leaves the cache untouched
      access(8'h45, 1, 8'h5A, 0, "R9", h);
      access(8'h21, 0, 8'h00, 0, "R9", h);
      chk("R9", "resident line still hits", int'(h), 1);
      access(8'h01, 0, 8'h00, 0, "R9", h);
      chk("R9", "other resident line still hits", int'(h), 1);
      access(8'h45, 0, 8'h00, 0, "R9", h);
      chk("R9", "bypassed line not allocated", int'(h), 0);
      access(8'h20, 1, 8'h77, 0, "R9", h);

      // mixed traffic over a narrow range
      seed = 12345;
      for (int k = 0; k < 400; k++) begin
         logic [7:0] a;
         bit we, al;
         seed = seed * 1103515245 + 12345;
         a  = 8'((seed >>> 8) & 8'h1F);
         we = ((seed >>> 16) & 3) == 0;
         al = ((seed >>> 20) & 1) == 1;
         access(a, we, 8'(seed >>> 24), al, "R2", h);
      end

      // R3 reset empties the cache
      do_reset();
      access(8'h00, 0, 8'h00, 1, "R3", h);
      chk("R3", "miss after reset", int'(h), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule